// File: doc/BRIEF.md
# Beam-Dump Post-Mortem Trigger

This block turns the loss of beam permit on either of two rings into event requests for a downstream event serialiser. Whenever a ring's permit flag drops, the block always asks for that ring's beam-dumped event. It also asks for one shared post-mortem event, but only when that ring is armed and the machine mode does not inhibit post-mortem.

Each ring has its own arm state. Decoded enable and disable strobes from the timing stream change it. A disable strobe also starts a re-arm timer that counts millisecond ticks. When the timer expires, the ring arms itself again, so the next permit loss triggers post-mortem once more.

A post-mortem request is released on a millisecond tick after the permit loss. If both rings become due on the same tick, the requests are issued on consecutive ticks and are never merged. The permit flags are asynchronous and pass through synchronisers before edge detection.

Top module: `pm_dump_trigger`

## Requirements
- R1: After reset both rings are disarmed, and both outputs are low. A permit loss before any enable strobe produces no post-mortem request.
- R2: A permit flag that goes from 1 to 0 produces a one-cycle pulse on that ring's bit of dump_req_o. The pulse comes three clock edges after the input changes. It appears whatever the arm state and the inhibit input are.
- R3: A permit loss on an armed ring, with inhibit low, produces exactly one pm_req_o pulse. The pulse is one cycle long and follows the PM_DELAY_TICKS-th tick after the loss (default 1). No pulse appears before that tick.
- R4: A permit loss on a disarmed ring produces no pm_req_o pulse.
- R5: If inhibit_i is high when the permit loss is detected, that loss produces no pm_req_o pulse.
- R6: An enable strobe arms its ring at once. A disable strobe disarms its ring at once, and disable takes priority if both strobes arrive together.
- R7: A disable strobe starts a re-arm timer for its ring. The ring is armed again at the REARM_TICKS-th tick after the strobe (default 2). A loss before that tick is ignored, and a loss after it triggers post-mortem.
- R8: An enable strobe while a re-arm timer is running cancels the timer and arms the ring immediately, with no tick needed.
- R9: If both rings are armed and lose permit in the same cycle, two pm_req_o pulses follow, on two consecutive ticks. No third pulse follows.
- R10: A permit flag that goes from 0 to 1 produces no request of either kind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| permit_i | input | RINGS | Asynchronous beam permit flags (1 = beam permitted), bit r for ring r |
| tick_i | input | 1 | One-cycle millisecond tick |
| enable_i | input | RINGS | Decoded enable-post-mortem strobes, one per ring |
| disable_i | input | RINGS | Decoded disable-post-mortem strobes, one per ring |
| inhibit_i | input | 1 | High in machine modes where post-mortem must not be sent |
| pm_req_o | output | 1 | One-cycle post-mortem event request |
| dump_req_o | output | RINGS | One-cycle beam-dumped event requests, one per ring |

## Verification
The bench drops permit flags under five conditions: a disarmed ring, an armed ring, an armed ring with inhibit high, both rings armed and dropping together, and a ring shortly after a disable strobe. These cases separate arm gating from inhibit gating, and show that dumped requests are unconditional. Counting the post-mortem pulses before and after each tick shows the tick delay. It also shows that two simultaneous losses are queued rather than merged. The disable, tick and enable sequences tell timer re-arming apart from immediate re-arming by an enable strobe. Raising the flags checks that rising edges are ignored.

// File: rtl/pm_dump_trigger.sv
module pm_dump_trigger #(
  parameter int RINGS          = 2,
  parameter int SYNC_STAGES    = 2,
  parameter int PM_DELAY_TICKS = 1,
  parameter int REARM_TICKS    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RINGS-1:0] permit_i,
  input  logic             tick_i,
  input  logic [RINGS-1:0] enable_i,
  input  logic [RINGS-1:0] disable_i,
  input  logic             inhibit_i,
  output logic             pm_req_o,
  output logic [RINGS-1:0] dump_req_o
);
  localparam int PW = $clog2(PM_DELAY_TICKS + 1);
  localparam int RW = $clog2(REARM_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q [RINGS];
  logic [RINGS-1:0] flag_now, flag_prev, fall;
  logic [RINGS-1:0] armed_q, wait_q, due_q, cand, grant;
  logic [PW-1:0]    wcnt_q  [RINGS];
  logic [RW-1:0]    rearm_q [RINGS];

  assign fall  = flag_prev & ~flag_now;
  assign grant = tick_i ? (cand & (~cand + RINGS'(1))) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flag_prev  <= '1;
      pm_req_o   <= 1'b0;
      dump_req_o <= '0;
    end else begin
      flag_prev  <= flag_now;
      pm_req_o   <= |grant;
      dump_req_o <= fall;
    end

  for (genvar r = 0; r < RINGS; r++) begin : g_ring
    assign flag_now[r] = sync_q[r][SYNC_STAGES-1];
    assign cand[r] = due_q[r] | (wait_q[r] & (wcnt_q[r] == PW'(1)));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[r] <= '1;
      else        sync_q[r] <= {sync_q[r][SYNC_STAGES-2:0], permit_i[r]};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        armed_q[r] <= 1'b0;
        rearm_q[r] <= '0;
      end else if (disable_i[r]) begin
        armed_q[r] <= 1'b0;
        rearm_q[r] <= RW'(REARM_TICKS);
      end else if (enable_i[r]) begin
        armed_q[r] <= 1'b1;
        rearm_q[r] <= '0;
      end else if (tick_i && rearm_q[r] != '0) begin
        rearm_q[r] <= rearm_q[r] - RW'(1);
        if (rearm_q[r] == RW'(1)) armed_q[r] <= 1'b1;
      end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wait_q[r] <= 1'b0;
        due_q[r]  <= 1'b0;
        wcnt_q[r] <= '0;
      end else if (fall[r] && armed_q[r] && !inhibit_i &&
                   (!(wait_q[r] || due_q[r]) || grant[r])) begin
        wait_q[r] <= 1'b1;
        due_q[r]  <= 1'b0;
        wcnt_q[r] <= PW'(PM_DELAY_TICKS);
      end else if (grant[r]) begin
        wait_q[r] <= 1'b0;
        due_q[r]  <= 1'b0;
      end else if (tick_i && cand[r]) begin
        wait_q[r] <= 1'b0;
        due_q[r]  <= 1'b1;
      end else if (tick_i && wait_q[r]) begin
        wcnt_q[r] <= wcnt_q[r] - PW'(1);
      end
  end
endmodule

module pm_dump_trigger_chk #(
  parameter int RINGS = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic [RINGS-1:0] enable_i,
  input logic [RINGS-1:0] disable_i,
  input logic             pm_req_o,
  input logic [RINGS-1:0] dump_req_o,
  input logic [RINGS-1:0] armed_q
);
  always @(posedge clk)
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!pm_req_o && dump_req_o == '0 && armed_q == '0);
    end

  p_pm_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req_o |-> $past(tick_i));

  for (genvar r = 0; r < RINGS; r++) begin : g_chk
    p_dump_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dump_req_o[r] |=> !dump_req_o[r]);
    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      disable_i[r] |=> !armed_q[r]);
    p_arm_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q[r]) |-> $past(enable_i[r] | tick_i));
  end
endmodule

bind pm_dump_trigger pm_dump_trigger_chk #(.RINGS(RINGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .enable_i(enable_i),
  .disable_i(disable_i), .pm_req_o(pm_req_o), .dump_req_o(dump_req_o),
  .armed_q(armed_q)
);

// File: tb/pm_dump_trigger_bench.sv
`timescale 1ns/1ps
module pm_dump_trigger_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] permit = 2'b11;
  logic       tick = 1'b0;
  logic [1:0] en = '0, dis = '0;
  logic       inhibit = 1'b0;
  logic       pm_req;
  logic [1:0] dump_req;

  int tests = 0, fails = 0;
  int pm_cnt = 0, dump0 = 0, dump1 = 0;

  always #5 clk = ~clk;

  pm_dump_trigger u_pm_dump_trigger (
    .clk(clk), .rst_n(rst_n), .permit_i(permit), .tick_i(tick),
    .enable_i(en), .disable_i(dis), .inhibit_i(inhibit),
    .pm_req_o(pm_req), .dump_req_o(dump_req)
  );

  always @(negedge clk) begin
    if (pm_req) pm_cnt++;
    if (dump_req[0]) dump0++;
    if (dump_req[1]) dump1++;
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    cyc(2);
  endtask

  task automatic drop(logic [1:0] m);
    @(negedge clk) permit = permit & ~m;
    cyc(6);
  endtask

  task automatic raise(logic [1:0] m);
    @(negedge clk) permit = permit | m;
    cyc(6);
  endtask

  task automatic strobe_en(logic [1:0] m);
    @(negedge clk) en = m;
    @(negedge clk) en = '0;
  endtask

  task automatic strobe_dis(logic [1:0] m);
    @(negedge clk) dis = m;
    @(negedge clk) dis = '0;
  endtask

  task automatic t_reset();
    int p;
    chk("R1 pm after reset", pm_req, 0);
    chk("R1 dump after reset", dump_req, 0);
    p = pm_cnt;
    drop(2'b01);
    chk("R2 dump ring0 while disarmed", dump0, 1);
    do_tick(); do_tick();
    chk("R1 R4 no pm when disarmed", pm_cnt, p);
    raise(2'b01);
    chk("R10 rise gives no dump", dump0, 1);
    chk("R10 rise gives no pm", pm_cnt, p);
  endtask

  task automatic t_dump_latency();
    int d;
    d = dump0;
    @(negedge clk) permit[0] = 1'b0;
    cyc(2);
    chk("R2 no dump before third edge", dump_req[0], 0);
    cyc(1);
    chk("R2 dump on third edge", dump_req[0], 1);
    cyc(1);
    chk("R2 dump one cycle", dump_req[0], 0);
    chk("R2 one dump pulse", dump0, d + 1);
    raise(2'b01);
  endtask

  task automatic t_armed();
    int p;
    strobe_en(2'b01);
    p = pm_cnt;
    drop(2'b01);
    chk("R3 no pm before tick", pm_cnt, p);
    do_tick();
    chk("R3 pm after tick", pm_cnt, p + 1);
    do_tick();
    chk("R3 single pm", pm_cnt, p + 1);
    raise(2'b01);
  endtask

  task automatic t_inhibit();
    int p, d;
    p = pm_cnt; d = dump0;
    inhibit = 1'b1;
    drop(2'b01);
    inhibit = 1'b0;
    chk("R2 dump under inhibit", dump0, d + 1);
    do_tick(); do_tick();
    chk("R5 no pm under inhibit", pm_cnt, p);
    raise(2'b01);
  endtask

  task automatic t_both();
    int p, d1;
    strobe_en(2'b11);
    p = pm_cnt; d1 = dump1;
    drop(2'b11);
    chk("R2 dump ring1", dump1, d1 + 1);
    do_tick();
    chk("R9 first pm", pm_cnt, p + 1);
    do_tick();
    chk("R9 second pm", pm_cnt, p + 2);
    do_tick();
    chk("R9 no third pm", pm_cnt, p + 2);
    raise(2'b11);
  endtask

  task automatic t_rearm();
    int p;
    strobe_dis(2'b10);
    p = pm_cnt;
    drop(2'b10);
    do_tick();
    chk("R6 R7 no pm while disarmed", pm_cnt, p);
    raise(2'b10);
    do_tick();
    drop(2'b10);
    do_tick();
    chk("R7 pm after re-arm", pm_cnt, p + 1);
    raise(2'b10);
  endtask

  task automatic t_cancel();
    int p;
    strobe_dis(2'b01);
    strobe_en(2'b01);
    p = pm_cnt;
    drop(2'b01);
    do_tick();
    chk("R8 R6 enable arms at once", pm_cnt, p + 1);
    raise(2'b01);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_dump_latency();
    t_armed();
    t_inhibit();
    t_both();
    t_rearm();
    t_cancel();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule